// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Unit

This unit is a watchdog whose settings can only be changed by software that first proves intent with a two-step key handshake. A free-running up-counter advances once per clock while counting is enabled. When the count equals a programmable limit, the unit latches an expiry flag. If reset generation is enabled, it also drives a fixed-length system reset pulse. Software keeps the system alive by servicing the watchdog (clearing the counter) before the limit is reached. Each service is also guarded by the key handshake.

Four registers are guarded: the control register (count enable and reset enable), the limit, the expiry flag and the service (counter clear) register. A guarded write is honoured only immediately after the handshake: key A written with 0xBABA and then key B written with 0xEB10. The unlock is used up by the next write of any kind, so every guarded write needs its own handshake. Reads never need the handshake and never disturb it.

Top module: `keyed_wdt`

## Requirements
- R1: Address map: key A at address 0, key B at address 1, control at 2, limit at 3, expiry flag at 4, service at 5, count (read-only) at 6. Writing 0x0000BABA to address 0, and then 0x0000EB10 to address 1 as the very next write, unlocks the unit. The write that follows is then accepted if it targets address 2, 3, 4 or 5.
- R2: A write to addresses 2 to 5 while the unit is not unlocked has no effect. A wrong key value, key B written without a correct key A just before it, or any other write placed between the two keys, leaves the unit locked.
- R3: One unlock allows exactly one write. After any write that follows an unlock, the unit is locked again, so a second guarded write without a new handshake is ignored.
- R4: Control bit 0 enables counting and bit 1 enables reset generation. The control register reads back both bits.
- R5: While counting is enabled, the count rises by one per cycle. In the cycle in which the count equals the limit (CNT_W bits wide), an expiry occurs and the count returns to 0. Starting from a count of 0, the expiry is seen limit+1 cycles after the write that enabled counting.
- R6: An expiry sets bit 0 of the expiry flag. An accepted write to address 4 with bit 0 equal to 0 clears the flag. An expiry in the same cycle wins over the clear.
- R7: With control bit 1 set, an expiry drives `wdt_reset` high from the next cycle for exactly RST_LEN cycles (8 by default). With bit 1 clear, expiries never raise `wdt_reset`.
- R8: An accepted write to address 5 sets the count to 0 and suppresses any expiry in that cycle. Regular servicing therefore keeps the expiry flag at 0.
- R9: `rd_data` shows the register at `rd_addr` in the same cycle, without an unlock. Key addresses read as 0. Reading does not change the unlock state.
- R10: After reset, control reads 0, the limit reads all ones, the flag and the count read 0, and `wdt_reset` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DATA_W | Read data for rd_addr |
| wdt_reset | output | 1 | System reset pulse |

## Verification
The bench builds the unit with CNT_W = 8 and the default RST_LEN = 8 and DATA_W = 32. The narrow counter makes the limit left by reset (255) reachable, so a full-range expiry completes in a few hundred cycles, next to the short 0xF limit and several random limits. Random streams of correct and wrong keys, out-of-order keys and guarded writes are compared with a bench model of the handshake, and the limit is read back after each attempt.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;

  typedef enum logic [2:0] {
    A_KEY1  = 3'd0,
    A_KEY2  = 3'd1,
    A_CTRL  = 3'd2,
    A_LIMIT = 3'd3,
    A_STAT  = 3'd4,
    A_KICK  = 3'd5,
    A_COUNT = 3'd6,
    A_SPARE = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;

  localparam logic [15:0] KEY1_VAL = 16'hBABA;
  localparam logic [15:0] KEY2_VAL = 16'hEB10;

  function automatic logic is_guarded(input logic [2:0] a);
    return (a == A_CTRL) || (a == A_LIMIT) || (a == A_STAT) || (a == A_KICK);
  endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_key_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked,
  output logic              guard_wr
);

  localparam logic [DATA_W-1:0] K1 = {{(DATA_W-16){1'b0}}, KEY1_VAL};
  localparam logic [DATA_W-1:0] K2 = {{(DATA_W-16){1'b0}}, KEY2_VAL};

  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_KEY1:  state_d = (wr_data == K1) ? LK_HALF : LK_IDLE;
        A_KEY2:  state_d = (state_q == LK_HALF && wr_data == K2) ? LK_OPEN : LK_IDLE;
        default: state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LK_IDLE;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == LK_OPEN);
  assign guard_wr = unlocked && wr_en && is_guarded(wr_addr);

  // R3
  single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en) |=> !unlocked);

  // R2
  key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_KEY2 && state_q != LK_HALF) |=> !unlocked);

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic             hit);
    return hit ? '0 : c + 1'b1;
  endfunction

  assign expire = run && !kick && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (kick) cnt_q <= '0;
    else if (run)  cnt_q <= step_count(cnt_q, expire);
  end

  assign count = cnt_q;

  // R8
  kick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count == '0));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == '0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !kick) |=> $stable(count));

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_out
);

  localparam int PW = $clog2(RST_LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= PW'(RST_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse_out = (left_q != '0);

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse_out);

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(fire));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_key_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wdt_reset
);

  logic             unlocked;
  logic             guard_wr;
  logic             wr_ctrl, wr_limit, wr_stat, wr_kick;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] limit_q;
  logic             status_q;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic             fire;

  wdt_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .unlocked (unlocked),
    .guard_wr (guard_wr)
  );

  assign wr_ctrl  = guard_wr && (wr_addr == A_CTRL);
  assign wr_limit = guard_wr && (wr_addr == A_LIMIT);
  assign wr_stat  = guard_wr && (wr_addr == A_STAT);
  assign wr_kick  = guard_wr && (wr_addr == A_KICK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      limit_q  <= '1;
      status_q <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_t'(wr_data[1:0]);
      if (wr_limit) limit_q <= wr_data[CNT_W-1:0];
      if (expire)                     status_q <= 1'b1;
      else if (wr_stat && !wr_data[0]) status_q <= 1'b0;
    end
  end

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q.run),
    .kick   (wr_kick),
    .limit  (limit_q),
    .count  (count),
    .expire (expire)
  );

  assign fire = expire && ctrl_q.rst_en;

  wdt_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .pulse_out (wdt_reset)
  );

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_CTRL:  rd_data[1:0]       = ctrl_q;
      A_LIMIT: rd_data[CNT_W-1:0] = limit_q;
      A_STAT:  rd_data[0]         = status_q;
      A_COUNT: rd_data[CNT_W-1:0] = count;
      default: rd_data            = '0;
    endcase
  end

  // R2
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && wr_en && wr_addr == A_CTRL) |=> $stable(ctrl_q));

  // R2
  locked_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && wr_en && wr_addr == A_LIMIT) |=> $stable(limit_q));

  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status_q);

  // R7
  no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.rst_en && !wdt_reset) |=> !$rose(wdt_reset));

endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          wdt_reset;

  int tests = 0;
  int fails = 0;

  keyed_wdt #(.DATA_W(DW), .CNT_W(CW), .RST_LEN(8)) u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wdt_reset(wdt_reset)
  );

  always #10 clk = ~clk;

  function automatic int exp_period(input int lim);
    return lim + 1;
  endfunction

  function automatic int lock_step(input int st, input int a, input logic [31:0] d);
    if (a == 0) return (d == 32'hBABA) ? 1 : 0;
    if (a == 1) return (st == 1 && d == 32'hEB10) ? 2 : 0;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic unlock();
    wr(3'd0, 32'hBABA);
    wr(3'd1, 32'hEB10);
  endtask

  task automatic gwr(input logic [2:0] a, input logic [31:0] d);
    unlock();
    wr(a, d);
  endtask

  task automatic measure(input int lim, input string req);
    int cyc = 0;
    int hi = 0;
    while (!wdt_reset && cyc < 600) begin @(negedge clk); cyc++; end
    chk({req, " expiry delay"}, cyc, exp_period(lim));
    while (wdt_reset && hi < 50) begin hi++; @(negedge clk); end
    chk("R7 pulse width", hi, 8);
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int st;
    logic [31:0] lim_m;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(3'd2, v); chk("R10 ctrl", v, 0);
    rd(3'd3, v); chk("R10 limit", v, 32'hFF);
    rd(3'd4, v); chk("R10 status", v, 0);
    rd(3'd6, v); chk("R10 count", v, 0);
    chk("R10 wdt_reset", wdt_reset, 0);

    // R2 locked writes ignored
    wr(3'd3, 32'h33); rd(3'd3, v); chk("R2 locked limit", v, 32'hFF);
    wr(3'd2, 32'h3);  rd(3'd2, v); chk("R2 locked ctrl", v, 0);

    // R1 unlock then write
    gwr(3'd3, 32'h0F); rd(3'd3, v); chk("R1 limit write", v, 32'h0F);
    // R3 unlock used up
    wr(3'd3, 32'h22); rd(3'd3, v); chk("R3 second write", v, 32'h0F);

    // R9 reads need no unlock and keep it
    unlock();
    rd(3'd0, v); chk("R9 key A reads 0", v, 0);
    rd(3'd1, v); chk("R9 key B reads 0", v, 0);
    rd(3'd3, v);
    wr(3'd3, 32'h0E); rd(3'd3, v); chk("R9 unlock kept over reads", v, 32'h0E);
    gwr(3'd3, 32'h0F);

    // R2 wrong value, wrong order, intervening write
    wr(3'd0, 32'hBABB); wr(3'd1, 32'hEB10); wr(3'd3, 32'h44);
    rd(3'd3, v); chk("R2 wrong key", v, 32'h0F);
    wr(3'd1, 32'hEB10); wr(3'd0, 32'hBABA); wr(3'd3, 32'h44);
    rd(3'd3, v); chk("R2 wrong order", v, 32'h0F);
    wr(3'd0, 32'hBABA); wr(3'd6, 32'h0); wr(3'd1, 32'hEB10); wr(3'd3, 32'h44);
    rd(3'd3, v); chk("R2 intervening write", v, 32'h0F);

    // R5 R7 expiry at limit 0xF with reset enabled
    gwr(3'd2, 32'h3);
    measure(15, "R5");
    rd(3'd4, v); chk("R6 status set", v, 1);
    gwr(3'd2, 32'h0);
    rd(3'd2, v); chk("R4 ctrl readback", v, 0);
    gwr(3'd5, 32'h0);
    rd(3'd6, v); chk("R8 kick clears count", v, 0);
    gwr(3'd4, 32'h0);
    rd(3'd4, v); chk("R6 status cleared", v, 0);

    // R7 count only: status but no reset
    begin
      int seen = 0;
      gwr(3'd2, 32'h1);
      rd(3'd2, v); chk("R4 ctrl run only", v, 1);
      repeat (40) begin @(negedge clk); if (wdt_reset) seen++; end
      chk("R7 no reset when bit1 clear", seen, 0);
      rd(3'd4, v); chk("R6 status with bit1 clear", v, 1);
    end
    gwr(3'd2, 32'h0);
    gwr(3'd5, 32'h0);
    gwr(3'd4, 32'h0);

    // R8 regular servicing
    gwr(3'd2, 32'h1);
    for (int k = 0; k < 6; k++) begin
      repeat (4) @(negedge clk);
      gwr(3'd5, 32'h0);
      rd(3'd6, v); chk("R8 count after service", v, 0);
    end
    rd(3'd4, v); chk("R8 serviced no expiry", v, 0);
    gwr(3'd2, 32'h0);
    gwr(3'd5, 32'h0);

    // R5 full-range limit
    gwr(3'd3, 32'hFF);
    gwr(3'd2, 32'h3);
    measure(255, "R5 full range");
    gwr(3'd2, 32'h0);
    repeat (12) @(negedge clk);

    // R5 random limits
    for (int t = 0; t < 3; t++) begin
      int lim = 1 + int'($urandom % 40);
      gwr(3'd2, 32'h0);
      gwr(3'd5, 32'h0);
      gwr(3'd3, 32'(lim));
      gwr(3'd2, 32'h3);
      measure(lim, "R5 random");
      gwr(3'd2, 32'h0);
      repeat (12) @(negedge clk);
    end
    gwr(3'd4, 32'h0);

    // R1 R2 R3 random key streams
    st = 0;
    rd(3'd3, lim_m);
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 4);
      logic [31:0] d;
      case (op)
        0: begin
          d = ($urandom % 2 == 0) ? 32'hBABA : $urandom;
          wr(3'd0, d); st = lock_step(st, 0, d);
        end
        1: begin
          d = ($urandom % 2 == 0) ? 32'hEB10 : $urandom;
          wr(3'd1, d); st = lock_step(st, 1, d);
        end
        2: begin
          d = $urandom;
          wr(3'd3, d);
          if (st == 2) lim_m = d & 32'hFF;
          st = 0;
          rd(3'd3, v); chk("R1 R3 random limit", v, lim_m);
        end
        default: begin
          wr(3'd6, $urandom); st = lock_step(st, 6, 0);
        end
      endcase
    end
    rd(3'd2, v); chk("R2 ctrl untouched by stream", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule